// File: doc/BRIEF.md
# I2C Combined-Transaction Master Sequencer

This block is a byte-level I2C master. Software programs it through a small register write port. It sets a 7-bit target address, a packed length word, an operation type and a few control bits, then writes the start register. The engine generates START, repeated START and STOP. It sends the address byte and moves data bytes between the bus and two byte streams: a TX stream it pulls from and an RX stream it pushes to, each with valid/ready. The pace of the bus comes from a `tick` input, and each tick advances one quarter of a bit. The clock pin and the data pin are driven as open-drain enables, where 1 means released.

A single start command can run two transfers back to back. The first is a write. Then comes a repeated START, the address goes out again, and the second transfer runs. Both byte counts come from one length word. Sticky status flags report completion, acknowledge errors and a transfer that ended on a repeated START. An interrupt output combines the flags with a mask.

Top module: `i2c_combo_master`

## Requirements
- R1: The address byte is the target address shifted left by one. Bit 0 is 1 only for the read operation (op code 2), or for the second phase of a combined transaction when the direction-change bit is set.
- R2: Op code 1 (write) and op code 0 take the byte count from the low byte of the length word (register select 1). They send that many TX bytes in the order they are accepted, each after a slave ACK, and then a STOP. Completion then sets status bit 0. A count of zero sends only the address byte.
- R3: Op code 2 (read) receives bytes MSB first and offers each one on the RX port, holding it until it is accepted. The engine ACKs every byte except the last, which it NACKs before the STOP.
- R4: Op code 3 (combined) writes the low-byte count. It then issues a repeated START and the address again, and runs the high-byte count in the second phase. No STOP occurs between the two phases.
- R5: Control bit 4 (control is register select 2) selects the direction of the second combined phase: 1 means read, 0 means another write.
- R6: When control bit 5 is set, a NACK on the address or on a write byte aborts the transaction. The engine then issues a STOP, sets status bit 1 and leaves status bit 0 clear.
- R7: When control bit 5 is clear, a NACK does not stop the transaction. The transaction completes with status bit 0 and bit 1 stays clear.
- R8: When control bit 1 is set, the transaction ends with a repeated START instead of a STOP. This sets status bits 0 and 4 and holds both lines low. The next start then sends the address without another START.
- R9: Status (register select 5) bits are cleared by writing 1 to them. The `irq` output is high exactly when some status bit and the same bit of the mask (register select 4) are both 1. Status bit 2 is never set.
- R10: A start write (register select 6, bit 0) while the engine is busy is ignored.
- R11: A soft-reset write (register select 7, bit 0) returns the engine to idle at once, releases both lines and clears all status bits. Operation selects are register select 3 and the target address is register select 0.
- R12: The bus lines change only one cycle after a `tick`. While the clock line is high, the data line changes only to form a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Quarter-bit advance strobe |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 2*LEN_W | Register write data |
| status | output | 5 | Sticky status flags |
| irq | output | 1 | Masked status interrupt |
| busy | output | 1 | Transaction in progress |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | TX byte available |
| tx_ready | output | 1 | Engine takes a TX byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Received byte offered |
| rx_ready | input | 1 | Consumer accepts RX byte |
| scl_o | output | 1 | Clock line enable, 1 = released |
| sda_o | output | 1 | Data line enable, 1 = released |
| sda_i | input | 1 | Data line as seen on the bus |

## Verification
A wrong phase, bit counter or remaining-byte count shows on the bus within the affected byte. It appears as a shifted address or data byte captured by the bench's slave model, a misplaced ACK or NACK, or a missing or extra START or STOP. A corrupted second-phase set-up shows up at the repeated START, where the re-sent address or the transfer direction comes out wrong. A wrong abort or completion decision is visible in the status flags and `irq` as soon as the STOP finishes.

// File: rtl/i2c_combo_master.sv
module i2c_combo_master #(
  parameter int LEN_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               reg_we,
  input  logic [2:0]         reg_sel,
  input  logic [2*LEN_W-1:0] reg_wdata,
  output logic [4:0]         status,
  output logic               irq,
  output logic               busy,
  input  logic [7:0]         tx_data,
  input  logic               tx_valid,
  output logic               tx_ready,
  output logic [7:0]         rx_data,
  output logic               rx_valid,
  input  logic               rx_ready,
  output logic               scl_o,
  output logic               sda_o,
  input  logic               sda_i
);
  localparam logic [2:0] SEL_TGT = 3'd0, SEL_LEN = 3'd1, SEL_CTL = 3'd2, SEL_OP = 3'd3,
                         SEL_MSK = 3'd4, SEL_STA = 3'd5, SEL_GO = 3'd6, SEL_RST = 3'd7;
  localparam logic [1:0] OP_RD = 2'd2, OP_COMBO = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_HOLD, S_START, S_SEND, S_LOAD, S_RBYTE, S_PUSH, S_STOP} st_t;

  st_t               st;
  logic [1:0]        ph;
  logic [3:0]        bitn;
  logic [7:0]        sh;
  logic [LEN_W-1:0]  cnt;
  logic [6:0]        tgt;
  logic [2*LEN_W-1:0] len_q;
  logic [1:0]        op_q;
  logic              ctl_rs, ctl_dir, ctl_ae;
  logic [4:0]        mask_q, stat_q;
  logic              rd, second, fin_rs, sr, nack, abort_q;

  wire go      = reg_we && reg_sel == SEL_GO  && reg_wdata[0];
  wire srst    = reg_we && reg_sel == SEL_RST && reg_wdata[0];
  wire last_ph = tick && ph == 2'd3;
  wire samp    = tick && ph == 2'd2;
  wire byte_done = last_ph && bitn == 4'd8 &&
                   ((st == S_SEND && !(nack && ctl_ae)) || st == S_RBYTE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= '0; bitn <= '0; sh <= '0; cnt <= '0;
      tgt <= '0; len_q <= '0; op_q <= '0; ctl_rs <= 1'b0; ctl_dir <= 1'b0; ctl_ae <= 1'b0;
      mask_q <= '0; stat_q <= '0;
      rd <= 1'b0; second <= 1'b0; fin_rs <= 1'b0; sr <= 1'b0; nack <= 1'b0; abort_q <= 1'b0;
    end else if (srst) begin
      st <= S_IDLE; ph <= '0; bitn <= '0; stat_q <= '0;
      second <= 1'b0; fin_rs <= 1'b0; sr <= 1'b0; nack <= 1'b0; abort_q <= 1'b0;
    end else begin
      if (reg_we) begin
        case (reg_sel)
          SEL_TGT: tgt <= reg_wdata[6:0];
          SEL_LEN: len_q <= reg_wdata;
          SEL_CTL: begin ctl_rs <= reg_wdata[1]; ctl_dir <= reg_wdata[4]; ctl_ae <= reg_wdata[5]; end
          SEL_OP:  op_q <= reg_wdata[1:0];
          SEL_MSK: mask_q <= reg_wdata[4:0];
          SEL_STA: stat_q <= stat_q & ~reg_wdata[4:0];
          default: ;
        endcase
      end
      if (tick && (st == S_START || st == S_SEND || st == S_RBYTE || st == S_STOP))
        ph <= ph + 2'd1;
      case (st)
        S_IDLE, S_HOLD: if (go) begin
          rd <= (op_q == OP_RD); second <= 1'b0; fin_rs <= 1'b0; abort_q <= 1'b0;
          cnt <= len_q[LEN_W-1:0]; ph <= '0; bitn <= '0; sr <= 1'b0;
          if (st == S_HOLD) begin st <= S_SEND; sh <= {tgt, op_q == OP_RD}; end
          else st <= S_START;
        end
        S_START: if (last_ph) begin
          if (fin_rs) begin
            st <= S_HOLD; fin_rs <= 1'b0; stat_q[0] <= 1'b1; stat_q[4] <= 1'b1;
          end else begin
            st <= S_SEND; sh <= {tgt, rd}; bitn <= '0;
          end
        end
        S_SEND: begin
          if (samp && bitn == 4'd8) nack <= sda_i;
          if (last_ph) begin
            if (bitn != 4'd8) begin sh <= {sh[6:0], 1'b0}; bitn <= bitn + 4'd1; end
            else if (nack && ctl_ae) begin st <= S_STOP; abort_q <= 1'b1; stat_q[1] <= 1'b1; end
          end
        end
        S_LOAD: if (tx_valid) begin
          sh <= tx_data; cnt <= cnt - 1'b1; bitn <= '0; st <= S_SEND;
        end
        S_RBYTE: begin
          if (samp && bitn != 4'd8) sh <= {sh[6:0], sda_i};
          if (last_ph && bitn < 4'd7) bitn <= bitn + 4'd1;
          if (last_ph && bitn == 4'd7) begin bitn <= 4'd8; cnt <= cnt - 1'b1; st <= S_PUSH; end
        end
        S_PUSH: if (rx_ready) st <= S_RBYTE;
        S_STOP: if (last_ph) begin
          st <= S_IDLE;
          if (!abort_q) stat_q[0] <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
      if (byte_done) begin
        bitn <= '0;
        if (cnt != '0) st <= rd ? S_RBYTE : S_LOAD;
        else if (op_q == OP_COMBO && !second) begin
          st <= S_START; second <= 1'b1; rd <= ctl_dir; sr <= 1'b1;
          cnt <= len_q[2*LEN_W-1:LEN_W];
        end else if (ctl_rs) begin
          st <= S_START; fin_rs <= 1'b1; sr <= 1'b1;
        end else st <= S_STOP;
      end
    end
  end

  wire scl_bit = (ph == 2'd1) || (ph == 2'd2);

  always_comb begin
    scl_o = 1'b1;
    sda_o = 1'b1;
    case (st)
      S_HOLD:  begin scl_o = 1'b0; sda_o = 1'b0; end
      S_START: begin scl_o = (ph == 2'd0) ? !sr : (ph != 2'd3); sda_o = (ph < 2'd2); end
      S_SEND:  begin scl_o = scl_bit; sda_o = (bitn == 4'd8) ? 1'b1 : sh[7]; end
      S_RBYTE: begin scl_o = scl_bit; sda_o = (bitn == 4'd8) ? (cnt == '0) : 1'b1; end
      S_LOAD, S_PUSH: scl_o = 1'b0;
      S_STOP:  begin scl_o = (ph != 2'd0); sda_o = (ph >= 2'd2); end
      default: ;
    endcase
  end

  assign status   = stat_q;
  assign irq      = |(stat_q & mask_q);
  assign busy     = (st != S_IDLE) && (st != S_HOLD);
  assign tx_ready = (st == S_LOAD);
  assign rx_valid = (st == S_PUSH);
  assign rx_data  = sh;

  p_tx_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready && tx_valid && !srst |=> st == S_SEND && bitn == 4'd0 && ph == 2'd0);
  p_rx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready && !srst |=> rx_valid && $stable(rx_data));
  p_ackerr_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[1]) |-> ctl_ae);
  p_restart_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[4]) |-> ctl_rs && stat_q[0]);
  p_scl_paced_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) && !$past(srst) |-> $stable(scl_o));
  p_sda_high_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(scl_o) && scl_o && (sda_o != $past(sda_o)) && !$past(srst) |->
    (st == S_START || st == S_STOP));
endmodule

// File: tb/test_i2c_combo_master.sv
module test_i2c_combo_master;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic [4:0] status;
  logic irq, busy, tx_ready, rx_valid, scl_o, sda_o, sda_i;
  logic [7:0] tx_data = '0, rx_data;
  logic tx_valid = 1'b1, rx_ready = 1'b1;
  logic slv_sda = 1'b1;

  assign sda_i = sda_o & slv_sda;

  i2c_combo_master #(.LEN_W(8)) i_i2c_combo_master (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .status(status), .irq(irq), .busy(busy),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_i));

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0, tick_en = 1, slow_rx = 0;
  logic [7:0] txq [32], sdat [32], sb [32], rxm [32];
  logic mack [32];
  int ntxm, nrxm, nsb, nsd, nmack, nstart, nstop, nack_idx;
  int bc = 0, tcnt = 0;
  bit txmode = 0, is_addr = 0, acked = 0;
  logic pscl = 1'b1, psda = 1'b1;
  logic [7:0] rxb = '0, tsh = '0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr_log();
    ntxm = 0; nrxm = 0; nsb = 0; nsd = 0; nmack = 0; nstart = 0; nstop = 0; nack_idx = 99;
    bc = 0; txmode = 0; is_addr = 0; slv_sda = 1'b1;
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic wait_idle(string req);
    int n = 0;
    while (busy && n < 20000) begin @(negedge clk); n++; end
    chk({req, " finishes"}, int'(n < 20000), 1);
  endtask

  task automatic setup(input logic [6:0] a, input logic [1:0] op, input logic [15:0] len,
                       input logic [15:0] ctl);
    clr_log();
    wr(3'd5, 16'h1F); wr(3'd0, {9'd0, a}); wr(3'd3, {14'd0, op});
    wr(3'd1, len); wr(3'd2, ctl);
  endtask

  // tick source, stream endpoints and slave model
  initial begin
    forever begin
      @(negedge clk);
      tcnt++;
      tick = tick_en && (tcnt % 3 == 0);
      rx_ready = !(slow_rx && (tcnt % 4 != 0));
      if (tx_ready) begin tx_data = txq[ntxm]; ntxm++; end
      if (rx_valid && rx_ready) begin rxm[nrxm] = rx_data; nrxm++; end
      if (scl_o && pscl && psda && !sda_i) begin
        nstart++; bc = 0; txmode = 0; is_addr = 1; slv_sda = 1'b1;
      end else if (scl_o && pscl && !psda && sda_i) begin
        nstop++; bc = 0; txmode = 0; slv_sda = 1'b1;
      end else if (scl_o && !pscl) begin
        if (bc < 8) begin if (!txmode) rxb = {rxb[6:0], sda_i}; bc++; end
        else if (bc == 8) begin if (txmode) begin mack[nmack] = sda_i; nmack++; end bc = 9; end
      end else if (!scl_o && pscl) begin
        if (bc == 8) begin
          if (!txmode) begin sb[nsb] = rxb; acked = (nsb != nack_idx); slv_sda = !acked; nsb++; end
          else slv_sda = 1'b1;
        end else if (bc == 9) begin
          bc = 0;
          if (is_addr) begin is_addr = 0; txmode = acked && rxb[0]; end
          else if (txmode && mack[nmack-1]) txmode = 0;
          if (txmode) begin tsh = sdat[nsd]; nsd++; slv_sda = tsh[7]; end
          else slv_sda = 1'b1;
        end else if (txmode && bc >= 1 && bc <= 7) slv_sda = tsh[7-bc];
      end
      pscl = scl_o; psda = sda_o & slv_sda;
    end
  end

  task automatic t_reset();
    @(negedge clk);
    chk("R11 reset status", status, 0);
    chk("R9 reset irq", irq, 0);
    chk("R11 reset busy", busy, 0);
    chk("R11 reset scl", scl_o, 1);
    chk("R11 reset sda", sda_o, 1);
  endtask

  task automatic t_write();
    logic s0, d0;
    setup(7'h50, 2'd1, 16'h0002, 16'h0000);
    txq[0] = 8'h11; txq[1] = 8'h22;
    wr(3'd6, 16'h1);
    repeat (30) @(negedge clk);
    tick_en = 0; repeat (2) @(negedge clk);
    s0 = scl_o; d0 = sda_o;
    repeat (40) @(negedge clk);
    chk("R12 scl frozen without tick", scl_o, s0);
    chk("R12 sda frozen without tick", sda_o, d0);
    chk("R12 still busy", busy, 1);
    tick_en = 1;
    wait_idle("R2");
    chk("R1 write address byte", sb[0], 8'hA0);
    chk("R2 first data", sb[1], 8'h11);
    chk("R2 second data", sb[2], 8'h22);
    chk("R2 bytes on bus", nsb, 3);
    chk("R2 tx consumed", ntxm, 2);
    chk("R2 stop count", nstop, 1);
    chk("R2 status", status, 5'h01);
  endtask

  task automatic t_read();
    setup(7'h29, 2'd2, 16'h0003, 16'h0000);
    sdat[0] = 8'hC5; sdat[1] = 8'h3A; sdat[2] = 8'h7E;
    slow_rx = 1;
    wr(3'd6, 16'h1);
    wait_idle("R3");
    slow_rx = 0;
    chk("R1 read address byte", sb[0], 8'h53);
    chk("R3 rx count", nrxm, 3);
    chk("R3 rx byte 0", rxm[0], 8'hC5);
    chk("R3 rx byte 1", rxm[1], 8'h3A);
    chk("R3 rx byte 2", rxm[2], 8'h7E);
    chk("R3 ack byte 0", mack[0], 0);
    chk("R3 ack byte 1", mack[1], 0);
    chk("R3 nack last", mack[2], 1);
    chk("R3 status", status, 5'h01);
  endtask

  task automatic t_combo_read();
    setup(7'h12, 2'd3, 16'h0201, 16'h0010);
    txq[0] = 8'h9C; sdat[0] = 8'h5B; sdat[1] = 8'hE0;
    wr(3'd6, 16'h1);
    wait_idle("R4");
    chk("R4 write address", sb[0], 8'h24);
    chk("R4 write data", sb[1], 8'h9C);
    chk("R5 read address after restart", sb[2], 8'h25);
    chk("R4 start count", nstart, 2);
    chk("R4 single stop", nstop, 1);
    chk("R4 rx count", nrxm, 2);
    chk("R4 rx byte 0", rxm[0], 8'h5B);
    chk("R4 rx byte 1", rxm[1], 8'hE0);
    chk("R4 nack last read", mack[1], 1);
    chk("R4 status", status, 5'h01);
  endtask

  task automatic t_combo_write();
    setup(7'h33, 2'd3, 16'h0101, 16'h0000);
    txq[0] = 8'h5A; txq[1] = 8'hA5;
    wr(3'd6, 16'h1);
    wait_idle("R5");
    chk("R5 bytes on bus", nsb, 4);
    chk("R5 second address write dir", sb[2], 8'h66);
    chk("R5 second phase data", sb[3], 8'hA5);
    chk("R5 start count", nstart, 2);
    chk("R5 status", status, 5'h01);
  endtask

  task automatic t_addr_nack();
    setup(7'h40, 2'd1, 16'h0002, 16'h0020);
    nack_idx = 0;
    wr(3'd6, 16'h1);
    wait_idle("R6");
    chk("R6 only address sent", nsb, 1);
    chk("R6 no tx taken", ntxm, 0);
    chk("R6 stop issued", nstop, 1);
    chk("R6 status ack error only", status, 5'h02);
  endtask

  task automatic t_data_nack_ignored();
    setup(7'h40, 2'd1, 16'h0002, 16'h0000);
    txq[0] = 8'h01; txq[1] = 8'h02; nack_idx = 1;
    wr(3'd6, 16'h1);
    wait_idle("R7");
    chk("R7 all bytes sent", nsb, 3);
    chk("R7 tx taken", ntxm, 2);
    chk("R7 status", status, 5'h01);
  endtask

  task automatic t_data_nack_abort();
    setup(7'h40, 2'd1, 16'h0003, 16'h0020);
    txq[0] = 8'h01; txq[1] = 8'h02; txq[2] = 8'h03; nack_idx = 1;
    wr(3'd6, 16'h1);
    wait_idle("R6");
    chk("R6 bytes before abort", nsb, 2);
    chk("R6 tx taken", ntxm, 1);
    chk("R6 stop after abort", nstop, 1);
    chk("R6 status after data nack", status, 5'h02);
  endtask

  task automatic t_restart_end();
    setup(7'h0A, 2'd1, 16'h0001, 16'h0002);
    txq[0] = 8'h77;
    wr(3'd6, 16'h1);
    wait_idle("R8");
    chk("R8 status complete+restart", status, 5'h11);
    chk("R8 no stop", nstop, 0);
    chk("R8 start count", nstart, 2);
    chk("R8 scl held low", scl_o, 0);
    chk("R8 sda held low", sda_o, 0);
    wr(3'd5, 16'h1F); wr(3'd2, 16'h0000); wr(3'd3, 16'h0002);
    sdat[0] = 8'h3C;
    wr(3'd6, 16'h1);
    wait_idle("R8");
    chk("R8 no extra start", nstart, 2);
    chk("R8 read address after hold", sb[2], 8'h15);
    chk("R8 rx byte", rxm[0], 8'h3C);
    chk("R8 stop at end", nstop, 1);
    chk("R8 status", status, 5'h01);
  endtask

  task automatic t_irq_zero_len();
    setup(7'h7F, 2'd1, 16'h0000, 16'h0000);
    wr(3'd4, 16'h0002);
    wr(3'd6, 16'h1);
    wait_idle("R2");
    chk("R2 zero length address only", nsb, 1);
    chk("R1 address byte", sb[0], 8'hFE);
    chk("R2 zero length tx", ntxm, 0);
    chk("R9 irq masked off", irq, 0);
    wr(3'd4, 16'h0001);
    chk("R9 irq on", irq, 1);
    wr(3'd5, 16'h0002);
    chk("R9 clear other bit keeps status", status, 5'h01);
    wr(3'd5, 16'h0001);
    chk("R9 status cleared", status, 0);
    chk("R9 irq off", irq, 0);
    wr(3'd4, 16'h0000);
  endtask

  task automatic t_go_busy();
    setup(7'h21, 2'd1, 16'h0002, 16'h0000);
    txq[0] = 8'hAA; txq[1] = 8'h55;
    wr(3'd6, 16'h1);
    repeat (40) @(negedge clk);
    wr(3'd6, 16'h1);
    wait_idle("R10");
    repeat (200) @(negedge clk);
    chk("R10 bytes on bus", nsb, 3);
    chk("R10 one start", nstart, 1);
    chk("R10 one stop", nstop, 1);
    chk("R10 idle afterwards", busy, 0);
    chk("R10 data intact", sb[2], 8'h55);
  endtask

  task automatic t_soft_reset();
    clr_log();
    wr(3'd1, 16'h0003); wr(3'd3, 16'h0001);
    txq[0] = 8'h0F; txq[1] = 8'hF0; txq[2] = 8'h81;
    wr(3'd6, 16'h1);
    repeat (60) @(negedge clk);
    chk("R11 status before reset", status, 5'h01);
    wr(3'd7, 16'h1);
    chk("R11 idle after reset", busy, 0);
    chk("R11 status cleared", status, 0);
    chk("R11 scl released", scl_o, 1);
    chk("R11 sda released", sda_o, 1);
    clr_log();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clr_log();
    t_reset();
    t_write();
    t_read();
    t_combo_read();
    t_combo_write();
    t_addr_nack();
    t_data_nack_ignored();
    t_data_nack_abort();
    t_restart_end();
    t_irq_zero_len();
    t_go_busy();
    t_soft_reset();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule